// File: doc/BRIEF.md
# Serial Gain and Offset Control Port

This block receives control words for an imaging front-end over two wires, a serial clock and a serial data line, with no chip-select. It keeps three control values on parallel outputs for the converters that follow it: a 3-bit maximum-gain range select, an 8-bit gain code and a 6-bit black-level offset code. Both wires come from a slow external master. They pass through synchronizers into the fast system clock, and all edge detection happens in that domain.

A transfer is ten bits, D9 first and D0 last, each captured on a rising serial clock edge. The data line must be low whenever the serial clock falls during the transfer. To commit a word, the master runs one dummy clock cycle. It raises the data line before that cycle's falling edge, which arms a store. It then drops the data line, and that falling edge writes the frame into the register chosen by D1..D0. A store request that arrives before a whole frame and its dummy bit have been shifted is refused and flagged. Holding the standby input low returns every register to its reset value.

Top module: `sctl_port`

## Requirements
- R1: Each rising edge of sck (after synchronization) shifts sdata in. The frame committed by a store is the ten bits shifted before the dummy clock's bit, with the first bit sent as D9 and the last as D0. The dummy bit itself is discarded.
- R2: A falling edge of sck while sdata is high arms a store. The next falling edge of sdata performs the store, and the register outputs change within a few system clocks of that edge.
- R3: A falling edge of sdata with no armed store writes nothing and produces no strobe. This includes partial frames and data-line glitches while sck is low.
- R4: Address D1D0=00 writes gain_sel with d0=D9, d1=D8, d2=D7. D6..D2 are ignored for this register.
- R5: Address D1D0=01 writes gain_code with d0=D9 through d7=D2.
- R6: Address D1D0=10 writes ofs_code with d0=D7 through d5=D2. D9 and D8 are ignored.
- R7: Address D1D0=11 changes no register, but the store is still strobed with wr_addr=3.
- R8: While rst is high or stby_n is low, gain_sel=0, gain_code=0 and ofs_code=32. Frames sent during standby have no effect.
- R9: A store request made after fewer than eleven rising sck edges (ten frame bits plus the dummy bit) since the last store request or reset writes nothing and gives no strobe. It pulses early_err for one cycle instead.
- R10: Every accepted store pulses wr_stb for exactly one system clock, with wr_addr holding D1D0 of the stored frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the sck rate |
| rst | input | 1 | Synchronous active-high reset |
| stby_n | input | 1 | Standby, active low; clears the registers and the shift state |
| sck | input | 1 | Serial clock from the external master |
| sdata | input | 1 | Serial data; also carries the store condition |
| gain_sel | output | 3 | Maximum-gain range select |
| gain_code | output | 8 | Gain code |
| ofs_code | output | 6 | Black-level offset code |
| wr_stb | output | 1 | One-cycle pulse per accepted store |
| wr_addr | output | 2 | Address of the last accepted store |
| early_err | output | 1 | One-cycle pulse for a refused, premature store |

## Verification
The bench builds the block with three synchronizer stages instead of the default two and keeps the default reset values. The longer input latency must not change which frame is captured or when the store happens. Serial phases of eight system clocks hold every edge apart, so each bit and each store maps to exactly one synchronized event. This also allows a nine-bit frame followed by a store to be aimed directly at the eleven-edge acceptance boundary.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

    localparam int FRAME_W = 10;
    localparam int ADDR_W  = 2;
    localparam int SEL_W   = 3;
    localparam int GAIN_W  = 8;
    localparam int OFS_W   = 6;

    // frame bits plus the dummy bit that must precede an accepted store
    localparam int EDGE_LIM = FRAME_W + 1;
    localparam int CNT_W    = $clog2(EDGE_LIM + 1);

    typedef enum logic [ADDR_W-1:0] {
        ADR_SEL  = 2'd0,
        ADR_GAIN = 2'd1,
        ADR_OFS  = 2'd2,
        ADR_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [GAIN_W-1:0] gain;
        logic [OFS_W-1:0]  ofs;
    } ctrl_regs_t;

    typedef struct packed {
        logic               req;    // store requested this cycle
        logic               full;   // enough edges seen since last request
        logic [FRAME_W-1:0] frame;  // [FRAME_W-1] is first bit sent
    } store_req_t;

    // payload is sent LSB first, so the first bit lands in the frame MSB
    function automatic logic [SEL_W-1:0] rev_sel(input logic [SEL_W-1:0] v);
        logic [SEL_W-1:0] r;
        for (int i = 0; i < SEL_W; i++) r[i] = v[SEL_W-1-i];
        return r;
    endfunction

    function automatic logic [GAIN_W-1:0] rev_gain(input logic [GAIN_W-1:0] v);
        logic [GAIN_W-1:0] r;
        for (int i = 0; i < GAIN_W; i++) r[i] = v[GAIN_W-1-i];
        return r;
    endfunction

    function automatic logic [OFS_W-1:0] rev_ofs(input logic [OFS_W-1:0] v);
        logic [OFS_W-1:0] r;
        for (int i = 0; i < OFS_W; i++) r[i] = v[OFS_W-1-i];
        return r;
    endfunction

endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] pipe;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
            prev <= 1'b0;
        end else begin
            pipe <= {pipe[STAGES-2:0], din};
            prev <= pipe[STAGES-1];
        end
    end

    assign lvl  = pipe[STAGES-1];
    assign rise = pipe[STAGES-1] & ~prev;
    assign fall = ~pipe[STAGES-1] & prev;
endmodule

// File: rtl/sctl_shifter.sv
module sctl_shifter
    import sctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       sck_rise,
    input  logic       sck_fall,
    input  logic       sd_lvl,
    input  logic       sd_fall,
    output store_req_t st
);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(EDGE_LIM);

    logic [FRAME_W-1:0] hist;    // bits held one edge behind the line
    logic               pend;    // newest sampled bit (the dummy at store time)
    logic [CNT_W-1:0]   edges;
    logic               armed;
    logic               req;

    assign req = sd_fall & armed;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hist  <= '0;
            pend  <= 1'b0;
            edges <= '0;
            armed <= 1'b0;
        end else begin
            if (sck_rise) begin
                hist <= {hist[FRAME_W-2:0], pend};
                pend <= sd_lvl;
                if (edges != LIM) edges <= edges + 1'b1;
            end
            if (sck_fall && sd_lvl) armed <= 1'b1;
            if (req) begin
                armed <= 1'b0;
                edges <= '0;
            end
        end
    end

    always_comb begin
        st.req   = req;
        st.full  = (edges == LIM);
        st.frame = hist;
    end
endmodule

// File: rtl/sctl_regfile.sv
module sctl_regfile
    import sctl_pkg::*;
#(
    parameter logic [SEL_W-1:0]  SEL_RESET  = '0,
    parameter logic [GAIN_W-1:0] GAIN_RESET = '0,
    parameter logic [OFS_W-1:0]  OFS_RESET  = OFS_W'(32)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  store_req_t        st,
    output ctrl_regs_t        regs,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              early_err
);
    reg_addr_e addr;
    logic      accept;

    assign addr   = reg_addr_e'(st.frame[ADDR_W-1:0]);
    assign accept = st.req & st.full;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            regs.sel  <= SEL_RESET;
            regs.gain <= GAIN_RESET;
            regs.ofs  <= OFS_RESET;
            wr_stb    <= 1'b0;
            wr_addr   <= '0;
            early_err <= 1'b0;
        end else begin
            wr_stb    <= accept;
            early_err <= st.req & ~st.full;
            if (accept) begin
                wr_addr <= addr;
                case (addr)
                    ADR_SEL:  regs.sel  <= rev_sel(st.frame[FRAME_W-1 -: SEL_W]);
                    ADR_GAIN: regs.gain <= rev_gain(st.frame[FRAME_W-1 -: GAIN_W]);
                    ADR_OFS:  regs.ofs  <= rev_ofs(st.frame[ADDR_W +: OFS_W]);
                    default:  ;
                endcase
            end
        end
    end
endmodule

// File: rtl/sctl_port.sv
module sctl_port
    import sctl_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [SEL_W-1:0]  SEL_RESET   = '0,
    parameter logic [GAIN_W-1:0] GAIN_RESET  = '0,
    parameter logic [OFS_W-1:0]  OFS_RESET   = OFS_W'(32)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stby_n,
    input  logic              sck,
    input  logic              sdata,
    output logic [SEL_W-1:0]  gain_sel,
    output logic [GAIN_W-1:0] gain_code,
    output logic [OFS_W-1:0]  ofs_code,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              early_err
);
    logic       sck_lvl, sck_rise, sck_fall;
    logic       sd_lvl, sd_rise, sd_fall;
    logic       clr;
    store_req_t st;
    ctrl_regs_t regs;

    assign clr = ~stby_n;

    sctl_sync #(.STAGES(SYNC_STAGES)) u_sync_sck (
        .clk(clk), .rst(rst), .din(sck),
        .lvl(sck_lvl), .rise(sck_rise), .fall(sck_fall)
    );

    sctl_sync #(.STAGES(SYNC_STAGES)) u_sync_sd (
        .clk(clk), .rst(rst), .din(sdata),
        .lvl(sd_lvl), .rise(sd_rise), .fall(sd_fall)
    );

    sctl_shifter u_shift (
        .clk(clk), .rst(rst), .clr(clr),
        .sck_rise(sck_rise), .sck_fall(sck_fall),
        .sd_lvl(sd_lvl), .sd_fall(sd_fall),
        .st(st)
    );

    sctl_regfile #(
        .SEL_RESET(SEL_RESET), .GAIN_RESET(GAIN_RESET), .OFS_RESET(OFS_RESET)
    ) u_regs (
        .clk(clk), .rst(rst), .clr(clr), .st(st),
        .regs(regs), .wr_stb(wr_stb), .wr_addr(wr_addr), .early_err(early_err)
    );

    assign gain_sel  = regs.sel;
    assign gain_code = regs.gain;
    assign ofs_code  = regs.ofs;

    // level and rise of synchronized lines are only needed for edge finding
    logic unused_ok;
    assign unused_ok = &{1'b0, sck_lvl, sd_rise};
endmodule

// File: rtl/sctl_port_chk.sv
module sctl_port_chk
    import sctl_pkg::*;
#(
    parameter logic [SEL_W-1:0]  SEL_RESET  = '0,
    parameter logic [GAIN_W-1:0] GAIN_RESET = '0,
    parameter logic [OFS_W-1:0]  OFS_RESET  = OFS_W'(32)
) (
    input logic              clk,
    input logic              rst,
    input logic              stby_n,
    input logic [SEL_W-1:0]  gain_sel,
    input logic [GAIN_W-1:0] gain_code,
    input logic [OFS_W-1:0]  ofs_code,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              early_err
);
    a_r10_strobe_single: assert property (@(posedge clk) disable iff (rst || !stby_n)
        wr_stb |=> !wr_stb);

    a_r3_no_write_without_strobe: assert property (@(posedge clk) disable iff (rst || !stby_n)
        (!wr_stb && $past(stby_n) && !$past(rst)) |->
            ($stable(gain_sel) && $stable(gain_code) && $stable(ofs_code)));

    a_r4_sel_only: assert property (@(posedge clk) disable iff (rst || !stby_n)
        (wr_stb && wr_addr == 2'd0) |-> ($stable(gain_code) && $stable(ofs_code)));

    a_r5_gain_only: assert property (@(posedge clk) disable iff (rst || !stby_n)
        (wr_stb && wr_addr == 2'd1) |-> ($stable(gain_sel) && $stable(ofs_code)));

    a_r6_ofs_only: assert property (@(posedge clk) disable iff (rst || !stby_n)
        (wr_stb && wr_addr == 2'd2) |-> ($stable(gain_sel) && $stable(gain_code)));

    a_r7_none_keeps: assert property (@(posedge clk) disable iff (rst || !stby_n)
        (wr_stb && wr_addr == 2'd3) |->
            ($stable(gain_sel) && $stable(gain_code) && $stable(ofs_code)));

    a_r8_standby_clears: assert property (@(posedge clk) disable iff (rst)
        !stby_n |=> (gain_sel == SEL_RESET && gain_code == GAIN_RESET && ofs_code == OFS_RESET));

    a_r9_early_no_write: assert property (@(posedge clk) disable iff (rst || !stby_n)
        early_err |-> (!wr_stb && $stable(gain_sel) && $stable(gain_code) && $stable(ofs_code)));
endmodule

bind sctl_port sctl_port_chk #(
    .SEL_RESET(SEL_RESET), .GAIN_RESET(GAIN_RESET), .OFS_RESET(OFS_RESET)
) u_chk (
    .clk(clk), .rst(rst), .stby_n(stby_n),
    .gain_sel(gain_sel), .gain_code(gain_code), .ofs_code(ofs_code),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .early_err(early_err)
);

// File: tb/tb_sctl_port.sv
module tb_sctl_port;
    localparam int CLK_PERIOD = 10;
    localparam int PH = 8;            // system clocks per serial phase
    localparam int NVEC = 8;

    // {frame[9:0], exp_addr[1:0], exp_sel[2:0], exp_gain[7:0], exp_ofs[5:0]}
    localparam logic [28:0] VEC [NVEC] = '{
        {10'h280, 2'd0, 3'd5, 8'h00, 6'd32},
        {10'h1A5, 2'd1, 3'd5, 8'h96, 6'd32},
        {10'h3D2, 2'd2, 3'd5, 8'h96, 6'd11},
        {10'h3FF, 2'd3, 3'd5, 8'h96, 6'd11},
        {10'h37C, 2'd0, 3'd3, 8'h96, 6'd11},
        {10'h3FD, 2'd1, 3'd3, 8'hFF, 6'd11},
        {10'h0FE, 2'd2, 3'd3, 8'hFF, 6'd63},
        {10'h201, 2'd1, 3'd3, 8'h01, 6'd63}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stby_n = 1'b1;
    logic       sck = 1'b0;
    logic       sdata = 1'b0;
    logic [2:0] gain_sel;
    logic [7:0] gain_code;
    logic [5:0] ofs_code;
    logic       wr_stb;
    logic [1:0] wr_addr;
    logic       early_err;

    int checks = 0;
    int fails = 0;
    int stb_cnt = 0;
    int err_cnt = 0;
    logic [1:0] last_addr = 2'd0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sctl_port #(.SYNC_STAGES(3)) dut (
        .clk(clk), .rst(rst), .stby_n(stby_n), .sck(sck), .sdata(sdata),
        .gain_sel(gain_sel), .gain_code(gain_code), .ofs_code(ofs_code),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .early_err(early_err)
    );

    always @(negedge clk) begin
        if (wr_stb) begin
            stb_cnt <= stb_cnt + 1;
            last_addr <= wr_addr;
        end
        if (early_err) err_cnt <= err_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one protocol bit: data set with sck low, dropped before sck falls
    task automatic send_bit(input logic b);
        sdata = b;    wait_clk(PH);
        sck = 1'b1;   wait_clk(PH);
        sdata = 1'b0; wait_clk(PH);
        sck = 1'b0;   wait_clk(PH);
    endtask

    task automatic send_bits(input logic [9:0] f, input int n);
        for (int i = 9; i > 9 - n; i--) send_bit(f[i]);
    endtask

    // dummy cycle: raise data during high phase, fall arms, data fall stores
    task automatic store_seq();
        sdata = 1'b0; wait_clk(PH);
        sck = 1'b1;   wait_clk(PH);
        sdata = 1'b1; wait_clk(PH);
        sck = 1'b0;   wait_clk(PH);
        sdata = 1'b0; wait_clk(4*PH);
    endtask

    task automatic chk_regs(input string req, input logic [2:0] s,
                            input logic [7:0] g, input logic [5:0] o);
        chk(gain_sel == s, req, "gain_sel", gain_sel, s);
        chk(gain_code == g, req, "gain_code", gain_code, g);
        chk(ofs_code == o, req, "ofs_code", ofs_code, o);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int s0;
        int e0;
        wait_clk(6);
        rst = 1'b0;
        wait_clk(4);

        // R8: reset values
        chk_regs("R8", 3'd0, 8'd0, 6'd32);
        chk(wr_stb == 1'b0 && early_err == 1'b0, "R8", "pulses idle", wr_stb, 0);

        // R1 R2 R4 R5 R6 R7 R10: table walk
        for (int v = 0; v < NVEC; v++) begin
            s0 = stb_cnt;
            send_bits(VEC[v][28:19], 10);
            store_seq();
            chk(stb_cnt == s0 + 1, "R10", "strobe count", stb_cnt - s0, 1);
            chk(last_addr == VEC[v][18:17], "R10", "strobe addr", last_addr, VEC[v][18:17]);
            chk(gain_sel == VEC[v][16:14], "R4 R1", "gain_sel", gain_sel, VEC[v][16:14]);
            chk(gain_code == VEC[v][13:6], "R5 R1", "gain_code", gain_code, VEC[v][13:6]);
            chk(ofs_code == VEC[v][5:0], "R6 R7", "ofs_code", ofs_code, VEC[v][5:0]);
        end

        // R3: frame without arm, then data-line glitch while sck low
        s0 = stb_cnt;
        send_bits(10'h1A5, 10);
        sdata = 1'b1; wait_clk(PH);
        sdata = 1'b0; wait_clk(4*PH);
        chk(stb_cnt == s0, "R3", "strobes on unarmed fall", stb_cnt - s0, 0);
        chk_regs("R3", 3'd3, 8'h01, 6'd63);

        // R9: nine bits plus dummy is one edge short (after a store resets count)
        send_bits(10'h3FD, 10);
        store_seq();
        chk(gain_code == 8'hFF, "R2", "gain after store", gain_code, 8'hFF);
        s0 = stb_cnt; e0 = err_cnt;
        send_bits(10'h201, 9);
        store_seq();
        chk(err_cnt == e0 + 1, "R9", "early_err pulses", err_cnt - e0, 1);
        chk(stb_cnt == s0, "R9", "no strobe", stb_cnt - s0, 0);
        chk(gain_code == 8'hFF, "R9", "gain unchanged", gain_code, 8'hFF);
        // count restarted by the refused request: a full frame is accepted
        send_bits(10'h201, 10);
        store_seq();
        chk(gain_code == 8'h01, "R9", "full frame after refusal", gain_code, 8'h01);
        chk(err_cnt == e0 + 1, "R9", "no extra error", err_cnt - e0, 1);

        // R8: standby clears and blocks writes
        stby_n = 1'b0; wait_clk(6);
        chk_regs("R8", 3'd0, 8'd0, 6'd32);
        s0 = stb_cnt;
        send_bits(10'h1A5, 10);
        store_seq();
        chk_regs("R8", 3'd0, 8'd0, 6'd32);
        chk(stb_cnt == s0, "R8", "no strobe in standby", stb_cnt - s0, 0);
        stby_n = 1'b1; wait_clk(6);
        chk_regs("R8", 3'd0, 8'd0, 6'd32);
        send_bits(10'h1A5, 10);
        store_seq();
        chk(gain_code == 8'h96, "R8", "write after release", gain_code, 8'h96);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule